// File: doc/BRIEF.md
# Two-Stage Pipelined 8-bit Processor Core

This block is a compact 8-bit processor core. Fetch and execute overlap: while one instruction executes, the next is read from memory. Code and data share a single external memory. The core reaches that memory through a 7-bit address output, an 8-bit read-data input, an 8-bit store-data output and an active-low write strobe. The memory is expected to answer combinationally, and the core captures the byte on its rising clock edge.

The core holds four 8-bit registers and two condition flags: Z for equal and C for no borrow. It decodes three 8-bit instruction shapes: register operations, a short immediate load, and conditional relative branches. When a load or store executes, the core inserts its own two memory cycles, so programs need no padding. A taken branch throws away the instruction that was being fetched. Reset is synchronous and active high, and execution starts from address 0 once reset is released.

Top module: `pipe8_core`

## Requirements
- R1: While reset is high, the address output is 0 and write enable is high. All four registers and both flags clear to zero, so a store executed first after reset writes 0 to address 0.
- R2: With no memory operation and no taken branch, the address output steps by one every cycle and one instruction completes per cycle.
- R3: A register instruction is encoded `0 ooo dd ss`, where dd is the destination and ss is the source. It computes as follows: ooo=000 gives Rd+Rs, 001 gives Rd−Rs, 010 gives Rd&Rs, 011 gives Rd|Rs and 100 copies Rs. Results wrap modulo 256.
- R4: ooo=101 compares Rd with Rs. It sets Z=(Rd==Rs) and C=(Rd>=Rs, unsigned) and writes no register. No other instruction changes the flags.
- R5: The immediate load is encoded `10 dd iiii`. It writes iiii into Rd with the upper four bits cleared.
- R6: A load (ooo=110) drives Rs on the address output for two cycles. At the end of the second cycle it writes the read data into Rd.
- R7: A store (ooo=111) drives Rs on the address output for two cycles. In the second cycle only, write enable is low and the store-data output carries Rd. Write enable is high in every other cycle.
- R8: A branch is encoded `11 cc ffff`. It is taken when cc=00 and Z=1, when cc=01 and Z=0, when cc=10 and C=1, and always when cc=11.
- R9: A taken branch at address N goes to N+2+sext(ffff), so ffff=1110 loops on itself. It flushes the instruction being fetched, which costs one bubble cycle.
- R10: A branch that is not taken costs no cycle, and the next instruction executes.
- R11: After a load or store, fetch resumes at the following address with one bubble cycle. That following instruction executes exactly once.
- R12: The fetch address wraps from 127 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 8 | Byte from memory: an instruction or load data |
| mem_addr | output | ADDR_W (7) | Memory address: the fetch pointer, or Rs during a memory operation |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_wdata | output | 8 | Store data (Rd) |

## Verification
The bench uses the default address width of 7 bits, so the full 128-byte space is in play. A program that runs a filler sled from address 5 to 127 reaches the wrap back to 0 in about 130 cycles. With this width, store pointers built by doubling an immediate reach the top eight bytes, out of the way of the code. One short program is traced cycle by cycle to pin down the load and store timing, the bubble that follows a memory operation, and the self-loop pattern.

// File: rtl/pipe8_pkg.sv
package pipe8_pkg;

    localparam int DATA_W  = 8;
    localparam int NREG    = 4;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int IMM_W   = 4;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [2:0] {
        ROP_ADD = 3'b000,
        ROP_SUB = 3'b001,
        ROP_AND = 3'b010,
        ROP_OR  = 3'b011,
        ROP_MOV = 3'b100,
        ROP_CMP = 3'b101,
        ROP_LDR = 3'b110,
        ROP_STR = 3'b111
    } rop_e;

    typedef enum logic [1:0] {
        BC_EQ = 2'b00,
        BC_NE = 2'b01,
        BC_CS = 2'b10,
        BC_AL = 2'b11
    } bcond_e;

    typedef enum logic [1:0] {
        FMT_REG = 2'b00,
        FMT_IMM = 2'b01,
        FMT_BR  = 2'b10
    } fmt_e;

    typedef enum logic {
        ST_EXEC = 1'b0,
        ST_MEM2 = 1'b1
    } stage_e;

    typedef struct packed {
        logic z;
        logic c;
    } flags_t;

    typedef struct packed {
        fmt_e              fmt;
        rop_e              rop;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rs;
        logic [IMM_W-1:0]  imm;
        bcond_e            cond;
    } dec_t;

    function automatic dec_t decode_instr(input word_t ins);
        dec_t d;
        d.rop  = rop_e'(ins[6:4]);
        d.imm  = ins[3:0];
        d.cond = bcond_e'(ins[5:4]);
        d.rs   = ins[1:0];
        if (!ins[7]) begin
            d.fmt = FMT_REG;
            d.rd  = ins[3:2];
        end else if (!ins[6]) begin
            d.fmt = FMT_IMM;
            d.rd  = ins[5:4];
        end else begin
            d.fmt = FMT_BR;
            d.rd  = ins[5:4];
        end
        return d;
    endfunction

    function automatic logic cond_met(input bcond_e cc, input flags_t f);
        case (cc)
            BC_EQ:   return f.z;
            BC_NE:   return !f.z;
            BC_CS:   return f.c;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/pipe8_regfile.sv
module pipe8_regfile
    import pipe8_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [$clog2(N)-1:0] ra_idx,
    input  logic [$clog2(N)-1:0] rb_idx,
    output logic [W-1:0]         ra_data,
    output logic [W-1:0]         rb_data,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] wa,
    input  logic [W-1:0]         wd
);
    localparam int IW = $clog2(N);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst)
                regs[i] <= '0;
            else if (we && wa == IW'(i))
                regs[i] <= wd;
        end
    end

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];

endmodule

// File: rtl/pipe8_alu.sv
module pipe8_alu
    import pipe8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  rop_e         op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] result,
    output flags_t       cmp_flags
);
    always_comb begin
        case (op)
            ROP_ADD: result = a + b;
            ROP_SUB: result = a - b;
            ROP_AND: result = a & b;
            ROP_OR:  result = a | b;
            ROP_MOV: result = b;
            default: result = a;
        endcase
    end

    assign cmp_flags.z = (a == b);
    assign cmp_flags.c = (a >= b);

endmodule

// File: rtl/pipe8_core.sv
module pipe8_core
    import pipe8_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr_n,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int SEXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] pc;
    word_t             ir;
    logic              ir_vld;
    stage_e            stage;
    flags_t            flags;

    dec_t   dec;
    word_t  ra_data, rb_data, alu_res, wr_data;
    flags_t alu_flags;
    logic   exec_vld, is_mem, mem_op, taken, fetch, cmp_exec, rf_we;
    logic [ADDR_W-1:0] target;

    assign dec      = decode_instr(ir);
    assign exec_vld = ir_vld && (stage == ST_EXEC);
    assign is_mem   = (dec.fmt == FMT_REG) && (dec.rop == ROP_LDR || dec.rop == ROP_STR);
    assign mem_op   = ir_vld && is_mem;
    assign taken    = exec_vld && (dec.fmt == FMT_BR) && cond_met(dec.cond, flags);
    assign fetch    = !mem_op;
    assign cmp_exec = exec_vld && (dec.fmt == FMT_REG) && (dec.rop == ROP_CMP);
    assign target   = pc + ADDR_W'(1) + ADDR_W'({{SEXT_W{dec.imm[IMM_W-1]}}, dec.imm});

    pipe8_regfile #(.N(NREG), .W(DATA_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_idx  (dec.rd),
        .rb_idx  (dec.rs),
        .ra_data (ra_data),
        .rb_data (rb_data),
        .we      (rf_we),
        .wa      (dec.rd),
        .wd      (wr_data)
    );

    pipe8_alu #(.W(DATA_W)) u_alu (
        .op        (dec.rop),
        .a         (ra_data),
        .b         (rb_data),
        .result    (alu_res),
        .cmp_flags (alu_flags)
    );

    always_comb begin
        rf_we   = 1'b0;
        wr_data = alu_res;
        if (stage == ST_MEM2) begin
            rf_we   = (dec.rop == ROP_LDR);
            wr_data = mem_rdata;
        end else if (exec_vld && dec.fmt == FMT_IMM) begin
            rf_we   = 1'b1;
            wr_data = DATA_W'(dec.imm);
        end else if (exec_vld && dec.fmt == FMT_REG) begin
            rf_we   = (dec.rop == ROP_ADD) || (dec.rop == ROP_SUB) || (dec.rop == ROP_AND)
                   || (dec.rop == ROP_OR)  || (dec.rop == ROP_MOV);
        end
    end

    assign mem_addr  = mem_op ? rb_data[ADDR_W-1:0] : pc;
    assign mem_wr_n  = !((stage == ST_MEM2) && (dec.rop == ROP_STR));
    assign mem_wdata = ra_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            ir     <= '0;
            ir_vld <= 1'b0;
            stage  <= ST_EXEC;
            flags  <= '0;
        end else begin
            if (stage == ST_MEM2) begin
                stage  <= ST_EXEC;
                ir_vld <= 1'b0;
            end else if (mem_op) begin
                stage  <= ST_MEM2;
            end else begin
                ir     <= mem_rdata;
                ir_vld <= !taken;
                pc     <= taken ? target : pc + ADDR_W'(1);
            end
            if (cmp_exec)
                flags <= alu_flags;
        end
    end

    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n |=> mem_wr_n);                                        // R7
    AST_STORE_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n |-> mem_addr == $past(mem_addr));                     // R7
    AST_MEM2_AFTER_MEM1: assert property (@(posedge clk) disable iff (rst)
        (stage == ST_MEM2) |-> ($past(stage) == ST_EXEC && mem_addr == $past(mem_addr))); // R6
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
        (fetch && !$past(rst) && $past(fetch) && !$past(taken))
            |-> mem_addr == $past(mem_addr) + ADDR_W'(1));              // R2
    AST_FLAGS_ONLY_CMP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cmp_exec)) |-> $stable(flags));          // R4

endmodule

// File: tb/tb_pipe8_core.sv
module tb_pipe8_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_rdata;
    logic [6:0] mem_addr;
    logic       mem_wr_n;
    logic [7:0] mem_wdata;

    always #5 clk = ~clk;

    pipe8_core #(.ADDR_W(7)) dut (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wr_n  (mem_wr_n),
        .mem_wdata (mem_wdata)
    );

    logic [7:0] mem  [0:127];
    logic [7:0] prog [0:127];
    logic       load_req = 1'b0;

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (load_req) begin
            for (int i = 0; i < 128; i++) mem[i] <= prog[i];
        end else if (!rst && !mem_wr_n) begin
            mem[mem_addr] <= mem_wdata;
        end
    end

    typedef struct {
        logic [6:0] a;
        logic [7:0] d;
        string      req;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   fails  = 0;
    int   wp;
    int   ptr;
    int   halt_at;
    logic wrap_seen;
    logic [6:0] prev_addr;

    function automatic logic [7:0] r_ins(int op, int rd, int rs);
        return {1'b0, op[2:0], rd[1:0], rs[1:0]};
    endfunction
    function automatic logic [7:0] i_ins(int rd, int imm);
        return {2'b10, rd[1:0], imm[3:0]};
    endfunction
    function automatic logic [7:0] b_ins(int cc, int off);
        return {2'b11, cc[1:0], off[3:0]};
    endfunction

    task automatic fail(string req, string what, int got, int exp);
        fails++;
        $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    endtask

    task automatic check(string req, string what, int got, int exp);
        checks++;
        if (got != exp) fail(req, what, got, exp);
    endtask

    task automatic emit(logic [7:0] ins);
        prog[wp] = ins;
        wp++;
    endtask

    task automatic push(int a, int d, string req);
        exp_t e;
        e.a = a[6:0]; e.d = d[7:0]; e.req = req;
        sbq.push_back(e);
    endtask

    // store R0 at [R3], then R3 += 1 using R2 as scratch
    task automatic st(int val, string req);
        emit(r_ins(7, 0, 3));
        push(ptr, val, req);
        ptr++;
        emit(i_ins(2, 1));
        emit(r_ins(0, 3, 2));
    endtask

    task automatic build_ptr();
        emit(i_ins(3, 15));
        emit(r_ins(0, 3, 3));
        emit(r_ins(0, 3, 3));
        emit(r_ins(0, 3, 3));
        ptr = 120;
    endtask

    task automatic halt();
        halt_at = wp;
        emit(b_ins(3, 14));
    endtask

    task automatic new_prog();
        for (int i = 0; i < 128; i++) prog[i] = 8'hFE;
        wp = 0;
    endtask

    task automatic start_prog();
        @(negedge clk);
        rst = 1'b1;
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        @(negedge clk);
        check("R1", "addr in reset", int'(mem_addr), 0);
        check("R1", "wr_n in reset", int'(mem_wr_n), 1);
        wrap_seen = 1'b0;
        rst = 1'b0;
    endtask

    task automatic finish_prog(string req);
        checks++;
        if (sbq.size() != 0) begin
            fail(req, "stores missing", sbq.size(), 0);
            sbq.delete();
        end
    endtask

    task automatic check_halt(string req);
        logic [6:0] x, y;
        x = mem_addr;
        @(negedge clk);
        y = mem_addr;
        checks++;
        if (!((int'(x) == halt_at && int'(y) == halt_at + 1) ||
              (int'(y) == halt_at && int'(x) == halt_at + 1)))
            fail(req, "self-loop addr pair", {x, 1'b0, y}, halt_at);
    endtask

    task automatic monitor();
        forever begin
            @(negedge clk);
            if (rst) begin
                prev_addr = '0;
            end else begin
                if (!mem_wr_n) begin
                    checks++;
                    if (sbq.size() == 0) begin
                        fail("R7", "unexpected store", int'({mem_addr, mem_wdata}), 0);
                    end else begin
                        exp_t e;
                        e = sbq.pop_front();
                        if (mem_addr !== e.a || mem_wdata !== e.d)
                            fail(e.req, "store addr/data", int'({mem_addr, mem_wdata}),
                                 int'({e.a, e.d}));
                    end
                end
                if (prev_addr == 7'd127 && mem_addr == 7'd0) wrap_seen = 1'b1;
                prev_addr = mem_addr;
            end
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        fork
            monitor();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fail("R2", "watchdog expired", 0, 1);
                summary();
                $finish;
            end
        join_none

        // ---- Program D: cycle trace of load, store and self loop (R6 R7 R11 R9 R2)
        new_prog();
        emit(i_ins(1, 9));       // 0: R1 = 9
        emit(r_ins(6, 0, 1));    // 1: R0 = mem[9]
        emit(i_ins(2, 12));      // 2: R2 = 12
        emit(r_ins(7, 0, 2));    // 3: mem[12] = R0
        halt();                  // 4
        prog[9] = 8'h5A;
        push(12, 8'h5A, "R7");
        start_prog();
        begin
            int exp_a [12] = '{0, 1, 9, 9, 2, 3, 12, 12, 4, 5, 4, 5};
            for (int k = 0; k < 12; k++) begin
                if (k > 0) @(negedge clk);
                check(k < 4 ? "R6" : (k < 6 ? "R11" : (k < 8 ? "R7" : "R9")),
                      $sformatf("trace addr s%0d", k), int'(mem_addr), exp_a[k]);
                check("R7", $sformatf("trace wr_n s%0d", k), int'(mem_wr_n), (k == 7) ? 0 : 1);
            end
        end
        finish_prog("R7");

        // ---- Program A: ALU ops, immediate, load/store round trip (R3 R5 R6 R7)
        new_prog();
        build_ptr();
        emit(i_ins(0, 9));  emit(i_ins(1, 5));  emit(r_ins(0, 0, 1)); st(14, "R3");
        emit(i_ins(0, 3));  emit(i_ins(1, 5));  emit(r_ins(1, 0, 1)); st(8'hFE, "R3");
        emit(i_ins(0, 12)); emit(i_ins(1, 3));  emit(r_ins(3, 0, 1)); st(15, "R5");
        emit(i_ins(1, 10)); emit(r_ins(2, 0, 1)); st(10, "R3");
        emit(i_ins(1, 7));  emit(r_ins(4, 0, 1)); st(7, "R3");
        emit(r_ins(4, 0, 3)); emit(r_ins(0, 0, 0)); emit(r_ins(0, 0, 0));
        st((ptr * 4) % 256, "R3");
        emit(i_ins(0, 13)); st(13, "R7");
        emit(r_ins(4, 1, 3)); emit(r_ins(1, 1, 2)); emit(r_ins(6, 0, 1)); st(13, "R6");
        halt();
        start_prog();
        check("R2", "first fetch addr", int'(mem_addr), 0);
        @(negedge clk);
        check("R2", "second fetch addr", int'(mem_addr), 1);
        repeat (150) @(negedge clk);
        finish_prog("R3");
        check_halt("R9");

        // ---- Program B: reset registers, flags and branch conditions (R1 R4 R8 R10 R9)
        new_prog();
        emit(r_ins(7, 0, 1));
        push(0, 0, "R1");
        build_ptr();
        begin
            int cx [6] = '{5, 5, 5, 5, 7, 0};
            int cy [6] = '{5, 6, 6, 6, 6, 9};
            int cc [6] = '{0, 1, 0, 2, 2, 3};
            int ev [6] = '{2, 2, 1, 1, 2, 2};
            for (int t = 0; t < 6; t++) begin
                emit(i_ins(0, 2)); emit(i_ins(1, cx[t])); emit(i_ins(2, cy[t]));
                emit(r_ins(5, 1, 2)); emit(b_ins(cc[t], 0)); emit(i_ins(0, 1));
                st(ev[t], (t == 2) ? "R10" : ((t == 5) ? "R9" : "R8"));
            end
        end
        // flags held across a non-compare instruction
        emit(i_ins(0, 2)); emit(i_ins(1, 5)); emit(i_ins(2, 5)); emit(r_ins(5, 1, 2));
        emit(r_ins(0, 1, 2)); emit(b_ins(1, 0)); emit(i_ins(0, 1)); st(1, "R4");
        // compare writes no register
        emit(i_ins(1, 7)); emit(i_ins(2, 6)); emit(r_ins(5, 1, 2)); emit(r_ins(4, 0, 1));
        st(7, "R4");
        halt();
        start_prog();
        repeat (190) @(negedge clk);
        finish_prog("R8");
        check_halt("R9");

        // ---- Program C: fetch pointer wrap (R12)
        new_prog();
        for (int i = 5; i < 126; i++) prog[i] = r_ins(4, 0, 0);
        prog[0]   = b_ins(2, 0);      // taken only once C=1
        prog[1]   = b_ins(3, 7);      // to 10
        prog[2]   = i_ins(1, 12);
        prog[3]   = r_ins(7, 1, 2);   // mem[R2=0] = R1
        prog[4]   = b_ins(3, 14);
        prog[126] = r_ins(5, 0, 0);   // Z=1 C=1
        prog[127] = r_ins(4, 0, 0);
        halt_at = 4;
        push(0, 12, "R12");
        start_prog();
        repeat (190) @(negedge clk);
        finish_prog("R12");
        check("R12", "addr wrap 127->0 seen", int'(wrap_seen), 1);
        check_halt("R12");

        summary();
        $finish;
    end

endmodule